// File: doc/BRIEF.md
# Stall-Cycle Attribution Counters

This block is a performance-monitoring counter set for a pipeline split into a back half (issue and execute) and a front half (fetch). Every clock the pipeline presents one strobe per stall reason for each half and a vector of detail reasons. The block counts all enabled clocks. For each half it counts the clocks in which that half is stalled, and it assigns each stalled clock to exactly one cause counter through a fixed priority order. The worst reason always takes the clock, so the cause counters of a half add up to that half's stall total.

The detail counters sit beside the cause counters and have no priority. Every asserted detail reason counts, so several can advance in the same clock. These strobes give the finer reasons behind the exception-detection wait, the operand wait and the register-stack wait. Software-side tools read any counter through an indexed read port with one cycle of latency. A global enable freezes the whole set, and a synchronous clear zeroes it.

Top module: `pmu_stall_attrib`

## Requirements
- R1: Counter 0 counts clocks: it advances by one on each rising edge where `en_i` is high and `clr_i` is low.
- R2: Counter 1 (back-half total) advances when any `be_stall_i` bit is set. Counter 2+NUM_BE (front-half total) advances when any `fe_stall_i` bit is set. The two halves count independently and may advance in the same clock, and neither total exceeds counter 0 before counter 0 wraps.
- R3: Back-half causes use counters 2..1+NUM_BE, with `be_stall_i` bit k on counter 2+k. Bit 0 (exception flush) has the highest priority, then branch-mispredict flush, exception-detection wait, operand wait, register-stack wait, and bit 5 (front-end starvation). Only the lowest-numbered set bit advances its counter.
- R4: Front-half causes use counters 3+NUM_BE onward, with `fe_stall_i` bit k on counter 3+NUM_BE+k. Bit 0 (front flush) has the highest priority, then translation miss, instruction-cache miss, branch recirculate, fill recirculate, prediction bubble, and bit 6 (instruction buffer full). Only the lowest-numbered set bit advances its counter.
- R5: Modulo 2^CNT_W, the cause counters of each half always add up to that half's total.
- R6: Detail counters follow the front-half causes, with `det_i` bit k on counter 3+NUM_BE+NUM_FE+k. Every set bit advances its own counter in the same clock, with no priority between them.
- R7: While `en_i` is low and `clr_i` is low, no counter and no overflow flag changes, whatever the strobes do.
- R8: A clock with `clr_i` high zeroes every counter and every overflow flag in that one clock, even when `en_i` is high.
- R9: Counters are CNT_W bits wide and wrap to zero after the all-ones value. The wrap sets that counter's sticky overflow flag, which only clear or reset removes.
- R10: `rd_data_o` and `rd_ovf_o` show the value and overflow flag of the counter selected by `rd_idx_i` at the previous rising edge. An index of NUM_CNT or above reads as zero.
- R11: Synchronous reset zeroes all counters, all overflow flags and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Counting enable |
| clr_i | input | 1 | Synchronous clear of all counters and flags |
| be_stall_i | input | NUM_BE | Back-half stall cause strobes, bit 0 highest priority |
| fe_stall_i | input | NUM_FE | Front-half stall cause strobes, bit 0 highest priority |
| det_i | input | NUM_DET | Detail stall reason strobes, unprioritized |
| rd_idx_i | input | IDX_W | Counter index to read |
| rd_data_o | output | CNT_W | Registered value of the selected counter |
| rd_ovf_o | output | 1 | Registered sticky overflow flag of the selected counter |

## Verification
The bench drives all cause strobes of a half at once, and a pattern with only the lowest-priority bits set. A reversed or missing priority encoder would advance the wrong cause counter or several of them, and the cause sums would then drift away from the total. It raises clear together with enable, where a design that let enable win would keep counting. It also drives strobes while enable is low, where a leaky gate would move the cause or detail counters.

A second instance with 4-bit counters wraps the clock counter. This exposes a missing sticky flag or an early flag one clock short of the wrap. Reads of indexes past the last counter expose a read mux that aliases them onto real counters.

// File: rtl/pmu_stall_pkg.sv
package pmu_stall_pkg;

  // Back-half stall causes, listed from highest to lowest priority.
  typedef enum logic [2:0] {
    BE_XCPT_FLUSH = 3'd0,
    BE_BR_FLUSH   = 3'd1,
    BE_DET_WAIT   = 3'd2,
    BE_OPND_WAIT  = 3'd3,
    BE_STK_WAIT   = 3'd4,
    BE_FE_STARVE  = 3'd5
  } be_cause_e;

  // Front-half stall causes, listed from highest to lowest priority.
  typedef enum logic [2:0] {
    FE_FLUSH      = 3'd0,
    FE_XLAT_MISS  = 3'd1,
    FE_ICACHE_MISS= 3'd2,
    FE_BR_RECIRC  = 3'd3,
    FE_FILL_RECIRC= 3'd4,
    FE_PRED_BUB   = 3'd5,
    FE_BUF_FULL   = 3'd6
  } fe_cause_e;

  // Counter layout within the bank.
  function automatic int cnt_total(int nbe, int nfe, int ndet);
    return 3 + nbe + nfe + ndet;
  endfunction

  function automatic int be_tot_idx();
    return 1;
  endfunction

  function automatic int fe_tot_idx(int nbe);
    return 2 + nbe;
  endfunction

  function automatic int det_base(int nbe, int nfe);
    return 3 + nbe + nfe;
  endfunction

endpackage

// File: rtl/pmu_prio_pick.sv
module pmu_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);

  logic taken;

  // Lowest index wins; the grant is one-hot or empty.
  always_comb begin
    gnt_o = '0;
    taken = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !taken) begin
        gnt_o[k] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/pmu_ctr_bank.sv
module pmu_ctr_bank #(
  parameter int N = 22,
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [N-1:0] inc_i,
  output logic [N*W-1:0] val_o,
  output logic [N-1:0] ovf_o
);

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic [W-1:0] cnt_q;
    logic         ovf_q;

    always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (en_i && inc_i[g]) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) ovf_q <= 1'b1;
      end
    end

    assign val_o[g*W +: W] = cnt_q;
    assign ovf_o[g]        = ovf_q;
  end

endmodule

// File: rtl/pmu_rd_port.sv
module pmu_rd_port #(
  parameter int N     = 22,
  parameter int W     = 48,
  parameter int IDX_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [N*W-1:0] val_i,
  input  logic [N-1:0]   ovf_i,
  output logic [W-1:0]   data_o,
  output logic           ovf_o
);

  logic [W-1:0] sel_val;
  logic         sel_ovf;

  always_comb begin
    sel_val = '0;
    sel_ovf = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (idx_i == IDX_W'(k)) begin
        sel_val = val_i[k*W +: W];
        sel_ovf = ovf_i[k];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      data_o <= sel_val;
      ovf_o  <= sel_ovf;
    end
  end

endmodule

// File: rtl/pmu_stall_attrib.sv
module pmu_stall_attrib
  import pmu_stall_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NUM_BE  = 6,
  parameter int NUM_FE  = 7,
  parameter int NUM_DET = 6,
  localparam int NUM_CNT = cnt_total(NUM_BE, NUM_FE, NUM_DET),
  localparam int IDX_W   = $clog2(NUM_CNT)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [NUM_BE-1:0]  be_stall_i,
  input  logic [NUM_FE-1:0]  fe_stall_i,
  input  logic [NUM_DET-1:0] det_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               rd_ovf_o
);

  localparam int IX_BE_TOT = be_tot_idx();
  localparam int IX_BE0    = IX_BE_TOT + 1;
  localparam int IX_FE_TOT = fe_tot_idx(NUM_BE);
  localparam int IX_FE0    = IX_FE_TOT + 1;
  localparam int IX_DET0   = det_base(NUM_BE, NUM_FE);

  logic [NUM_BE-1:0]      be_gnt;
  logic [NUM_FE-1:0]      fe_gnt;
  logic                   be_any;
  logic                   fe_any;
  logic [NUM_CNT-1:0]     inc_vec;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]     ovf_vec;

  pmu_prio_pick #(.N(NUM_BE)) u_be_pick (
    .req_i (be_stall_i),
    .gnt_o (be_gnt),
    .any_o (be_any)
  );

  pmu_prio_pick #(.N(NUM_FE)) u_fe_pick (
    .req_i (fe_stall_i),
    .gnt_o (fe_gnt),
    .any_o (fe_any)
  );

  always_comb begin
    inc_vec                      = '0;
    inc_vec[0]                   = 1'b1;
    inc_vec[IX_BE_TOT]           = be_any;
    inc_vec[IX_BE0 +: NUM_BE]    = be_gnt;
    inc_vec[IX_FE_TOT]           = fe_any;
    inc_vec[IX_FE0 +: NUM_FE]    = fe_gnt;
    inc_vec[IX_DET0 +: NUM_DET]  = det_i;
  end

  pmu_ctr_bank #(.N(NUM_CNT), .W(CNT_W)) u_bank (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (clr_i),
    .en_i  (en_i),
    .inc_i (inc_vec),
    .val_o (cnt_flat),
    .ovf_o (ovf_vec)
  );

  pmu_rd_port #(.N(NUM_CNT), .W(CNT_W), .IDX_W(IDX_W)) u_rd (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .idx_i  (rd_idx_i),
    .val_i  (cnt_flat),
    .ovf_i  (ovf_vec),
    .data_o (rd_data_o),
    .ovf_o  (rd_ovf_o)
  );

endmodule

// File: rtl/pmu_stall_attrib_chk.sv
module pmu_stall_attrib_chk #(
  parameter int CNT_W   = 48,
  parameter int NUM_BE  = 6,
  parameter int NUM_FE  = 7,
  parameter int NUM_DET = 6,
  parameter int NUM_CNT = 22,
  parameter int IDX_W   = 5
) (
  input logic                     clk_i,
  input logic                     rst_i,
  input logic                     en_i,
  input logic                     clr_i,
  input logic                     be_top_i,
  input logic [NUM_BE-1:0]        be_gnt,
  input logic [NUM_FE-1:0]        fe_gnt,
  input logic [IDX_W-1:0]         rd_idx_i,
  input logic [CNT_W-1:0]         rd_data_o,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT-1:0]       ovf_vec
);

  localparam int IX_BE0    = 2;
  localparam int IX_FE_TOT = 2 + NUM_BE;
  localparam int IX_FE0    = IX_FE_TOT + 1;

  logic [CNT_W-1:0] cyc, be_tot, fe_tot, be_sum, fe_sum, be_top_cnt, sel_now;

  always_comb begin
    cyc        = cnt_flat[0 +: CNT_W];
    be_tot     = cnt_flat[CNT_W +: CNT_W];
    fe_tot     = cnt_flat[IX_FE_TOT*CNT_W +: CNT_W];
    be_top_cnt = cnt_flat[IX_BE0*CNT_W +: CNT_W];
    be_sum = '0;
    for (int k = 0; k < NUM_BE; k++) be_sum = be_sum + cnt_flat[(IX_BE0+k)*CNT_W +: CNT_W];
    fe_sum = '0;
    for (int k = 0; k < NUM_FE; k++) fe_sum = fe_sum + cnt_flat[(IX_FE0+k)*CNT_W +: CNT_W];
    sel_now = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (rd_idx_i == IDX_W'(k)) sel_now = cnt_flat[k*CNT_W +: CNT_W];
  end

  assert_cycle_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !clr_i) |=> cyc == $past(cyc) + 1'b1);

  assert_total_le_cycles_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !ovf_vec[0] |-> (be_tot <= cyc && fe_tot <= cyc));

  assert_top_cause_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !clr_i && be_top_i) |=> be_top_cnt == $past(be_top_cnt) + 1'b1);

  assert_single_cause_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ($onehot0(be_gnt) && $onehot0(fe_gnt)));

  assert_cause_sum_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (be_sum == be_tot && fe_sum == fe_tot));

  assert_frozen_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !clr_i) |=> ($stable(cnt_flat) && $stable(ovf_vec)));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (cnt_flat == '0 && ovf_vec == '0));

  assert_read_latency_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> rd_data_o == $past(sel_now));

endmodule

bind pmu_stall_attrib pmu_stall_attrib_chk #(
  .CNT_W(CNT_W), .NUM_BE(NUM_BE), .NUM_FE(NUM_FE), .NUM_DET(NUM_DET),
  .NUM_CNT(NUM_CNT), .IDX_W(IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .en_i      (en_i),
  .clr_i     (clr_i),
  .be_top_i  (be_stall_i[0]),
  .be_gnt    (be_gnt),
  .fe_gnt    (fe_gnt),
  .rd_idx_i  (rd_idx_i),
  .rd_data_o (rd_data_o),
  .cnt_flat  (cnt_flat),
  .ovf_vec   (ovf_vec)
);

// File: tb/tb_pmu_stall_attrib.sv
module tb_pmu_stall_attrib;

  localparam int NBE = 6, NFE = 7, NDET = 6;
  localparam int NCNT = 3 + NBE + NFE + NDET;
  localparam int IW = $clog2(NCNT);
  localparam int SW = 4;
  localparam longint unsigned MASK_W = 64'hFFFF_FFFF_FFFF;
  localparam longint unsigned MASK_S = 64'hF;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, clr = 1'b0;
  logic [NBE-1:0] be = '0;
  logic [NFE-1:0] fe = '0;
  logic [NDET-1:0] det = '0;
  logic [IW-1:0] idx = '0;
  logic [47:0] rd_w;
  logic [SW-1:0] rd_s;
  logic ovf_w, ovf_s;

  longint unsigned mdl [NCNT];
  longint unsigned got [NCNT];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pmu_stall_attrib #(.CNT_W(48), .NUM_BE(NBE), .NUM_FE(NFE), .NUM_DET(NDET)) dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .clr_i(clr), .be_stall_i(be),
    .fe_stall_i(fe), .det_i(det), .rd_idx_i(idx), .rd_data_o(rd_w), .rd_ovf_o(ovf_w));

  pmu_stall_attrib #(.CNT_W(SW), .NUM_BE(NBE), .NUM_FE(NFE), .NUM_DET(NDET)) dut_small (
    .clk_i(clk), .rst_i(rst), .en_i(en), .clr_i(clr), .be_stall_i(be),
    .fe_stall_i(fe), .det_i(det), .rd_idx_i(idx), .rd_data_o(rd_s), .rd_ovf_o(ovf_s));

  function automatic int first_set(logic [15:0] v, int n);
    for (int k = 0; k < n; k++) if (v[k]) return k;
    return -1;
  endfunction

  function automatic string req_of(int i);
    if (i == 0) return "R1";
    if (i == 1 || i == 2 + NBE) return "R2";
    if (i < 2 + NBE) return "R3";
    if (i < 3 + NBE + NFE) return "R4";
    return "R6";
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic check(string req, string tag, int i, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] idx %0d: actual %0h expected %0h", req, tag, i, act, exp);
    end
  endtask

  task automatic step(logic e, logic c, logic [NBE-1:0] b, logic [NFE-1:0] f, logic [NDET-1:0] d);
    int p;
    @(negedge clk);
    en = e; clr = c; be = b; fe = f; det = d;
    if (c) begin
      foreach (mdl[i]) mdl[i] = 0;
    end else if (e) begin
      mdl[0]++;
      p = first_set(16'(b), NBE);
      if (p >= 0) begin mdl[1]++; mdl[2 + p]++; end
      p = first_set(16'(f), NFE);
      if (p >= 0) begin mdl[2 + NBE]++; mdl[3 + NBE + p]++; end
      for (int k = 0; k < NDET; k++) if (d[k]) mdl[3 + NBE + NFE + k]++;
    end
  endtask

  task automatic read_one(int i, string tag);
    @(negedge clk);
    en = 1'b0; clr = 1'b0; idx = IW'(i);
    @(negedge clk);
    got[i] = longint'(rd_w);
    check(req_of(i), tag, i, longint'(rd_w), mdl[i] & MASK_W);
    check(req_of(i), {tag, " ovf"}, i, longint'(ovf_w), longint'(mdl[i] > MASK_W));
    check(req_of(i), {tag, " narrow"}, i, longint'(rd_s), mdl[i] & MASK_S);
    check((mdl[i] > MASK_S) ? "R9" : req_of(i), {tag, " narrow ovf"}, i,
          longint'(ovf_s), longint'(mdl[i] > MASK_S));
  endtask

  task automatic read_all(string tag);
    longint unsigned sb, sf;
    for (int i = 0; i < NCNT; i++) read_one(i, tag);
    sb = 0; sf = 0;
    for (int k = 0; k < NBE; k++) sb += got[2 + k];
    for (int k = 0; k < NFE; k++) sf += got[3 + NBE + k];
    check("R5", {tag, " back sum"}, 1, sb, got[1]);
    check("R5", {tag, " front sum"}, 2 + NBE, sf, got[2 + NBE]);
    check("R2", {tag, " back<=cycles"}, 1, longint'(got[1] <= got[0]), 1);
    check("R2", {tag, " front<=cycles"}, 2 + NBE, longint'(got[2 + NBE] <= got[0]), 1);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    foreach (mdl[i]) mdl[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    read_all("R11 reset");

    // R3/R4/R6 directed: all strobes, then only low-priority ones
    step(1, 0, '1, '1, '1);
    step(1, 0, 6'b110000, 7'b1111110, 6'b000101);
    step(1, 0, 6'b100000, 7'b1000000, '0);
    step(1, 0, 6'b001100, '0, 6'b111000);
    step(1, 0, '0, 7'b0010100, '0);
    read_all("R3 R4 R6 directed");

    // R7: strobes while disabled
    repeat (5) step(0, 0, '1, '1, '1);
    read_all("R7 disabled");

    // R8: clear together with enable
    step(1, 0, '1, '1, '1);
    step(1, 1, '1, '1, '1);
    read_all("R8 clear");

    // R9: narrow clock counter one short of and at the wrap
    repeat (15) step(1, 0, '0, '0, '0);
    read_one(0, "R9 before wrap");
    step(1, 0, '0, '0, '0);
    read_one(0, "R9 at wrap");
    read_one(1, "R9 no wrap on total");

    // R10: indexes beyond the last counter
    for (int i = NCNT; i < (1 << IW); i += 3) begin
      @(negedge clk);
      en = 1'b0; idx = IW'(i);
      @(negedge clk);
      check("R10", "out of range", i, longint'(rd_w), 0);
      check("R10", "out of range ovf", i, longint'(ovf_w), 0);
    end

    // R5: random strobes
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < 2500; n++)
        step(($urandom % 10) != 0, ($urandom % 700) == 0,
             NBE'($urandom & $urandom), NFE'($urandom & $urandom), NDET'($urandom & $urandom));
      read_all("R5 random");
    end

    finish_run();
  end

endmodule